// File: doc/BRIEF.md
# Programmable Power-Down Timeout Timer

This block forces the device into power-down a programmed time after software sets it up. Software writes an 8-bit register whose upper five bits hold a binary timeout code. One code step is one coarse time unit of 71.5 seconds. A code of 31 therefore gives the longest delay, about 36.9 minutes, and a code of zero switches the timer off. The three low bits of the register are reserved: they are dropped on write and read back as zero.

Coarse time comes from an external, already prescaled `tick` pulse. One step is `STEP_TICKS` tick pulses, so the bench can use a short scaled tick. Writing a code starts a fresh countdown. When the last step elapses, `pd_req` rises, and `bal_override` rises in the same cycle. `bal_override` makes power-down win over any cell-balancing timers that are still running. Software should therefore program this timeout at least one step longer than every balancing timeout. Both outputs stay high until reset or until the next register write.

The register port is a plain strobe (`wr_en` with `wr_data`), and the readback on `rd_data` is always valid. A write is never held off, so the port has no back-pressure.

Top module: `pdt_timer`

## Requirements
- R1: While reset is asserted and after it is released, `rd_data` is 0x00 and both `pd_req` and `bal_override` are 0.
- R2: A write stores `wr_data[7:3]` as the code. From the next cycle, `rd_data` shows that code in bits [7:3] and 0 in bits [2:0], whatever was written to bits [2:0].
- R3: After a write of nonzero code N, `pd_req` stays 0 through the first N*STEP_TICKS-1 tick pulses. It is 1 in the cycle after the clock edge that samples tick pulse N*STEP_TICKS.
- R4: While the stored code is zero, `pd_req` and `bal_override` stay 0 for any number of tick pulses.
- R5: Once set, `pd_req` stays 1, through any tick pulses and idle cycles, until reset or a register write.
- R6: `bal_override` is 1 in exactly the cycles where `pd_req` is 1.
- R7: A register write clears `pd_req` in the next cycle and restarts the count from zero ticks. Tick pulses already counted toward a partial step are discarded.
- R8: A tick pulse sampled in the same cycle as a register write is not counted.
- R9: The largest code, 31, expires after exactly 31*STEP_TICKS tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data; bits [7:3] are the timeout code |
| rd_data | output | 8 | Register readback; bits [2:0] are always 0 |
| tick | input | 1 | Prescaled coarse time pulse, one cycle wide |
| pd_req | output | 1 | Power-down request, held after expiry |
| bal_override | output | 1 | Forces balancing timers off, asserted together with pd_req |

## Verification
The hardest cases are the boundaries of a partial step. These include a rewrite that lands after some ticks of a step have been counted, and a tick that coincides with the write strobe. Neither case can be seen at the ports until the full expiry count has run out. The directed tasks set each case up with exact tick counts. A rewrite after two ticks of a three-tick step must still need all three ticks afterwards. A tick held high during the write must not shorten the wait. Each task checks `pd_req` one tick before and one tick after the expected expiry.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int REG_W    = 8;
  localparam int CODE_W   = 5;
  localparam int CODE_LSB = REG_W - CODE_W;

  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [CODE_W-1:0] code_t;

  // Mask keeping only the timeout field; reserved low bits forced to zero.
  function automatic reg_t field_mask();
    reg_t m;
    for (int i = 0; i < REG_W; i++) m[i] = (i >= CODE_LSB);
    return m;
  endfunction

  function automatic code_t code_of(input reg_t r);
    return r[REG_W-1:CODE_LSB];
  endfunction
endpackage

// File: rtl/pdt_cfg_reg.sv
module pdt_cfg_reg
  import pdt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  reg_t  wr_data,
  output reg_t  cfg_q,
  output logic  load,
  output code_t load_code
);
  localparam reg_t KEEP = field_mask();

  reg_t wr_clean;
  assign wr_clean  = wr_data & KEEP;
  assign load      = wr_en;
  assign load_code = code_of(wr_clean);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_clean;
  end
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick_en,
  output logic step
);
  generate
    if (STEP_TICKS <= 1) begin : g_direct
      assign step = tick_en;
    end else begin : g_count
      localparam int CW = $clog2(STEP_TICKS);
      localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);
      logic [CW-1:0] cnt;
      assign step = tick_en && (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clear)   cnt <= '0;
        else if (tick_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pdt_countdown.sv
module pdt_countdown
  import pdt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t load_code,
  input  logic  step,
  output logic  armed,
  output logic  expired
);
  code_t remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      armed   <= 1'b0;
      expired <= 1'b0;
    end else if (load) begin
      remain  <= load_code;
      armed   <= |load_code;
      expired <= 1'b0;
    end else if (armed && step) begin
      if (remain == code_t'(1)) begin
        remain  <= '0;
        armed   <= 1'b0;
        expired <= 1'b1;
      end else begin
        remain  <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int STEP_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick,
  output logic       pd_req,
  output logic       bal_override
);
  logic  load;
  code_t load_code;
  logic  armed;
  logic  expired;
  logic  step;
  reg_t  cfg_q;

  pdt_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg_q     (cfg_q),
    .load      (load),
    .load_code (load_code)
  );

  // Ticks count only while a nonzero timeout runs; a write cycle's tick is dropped.
  pdt_prescaler #(.STEP_TICKS(STEP_TICKS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .tick_en (tick && armed && !load),
    .step    (step)
  );

  pdt_countdown u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_code (load_code),
    .step      (step),
    .armed     (armed),
    .expired   (expired)
  );

  assign rd_data      = cfg_q;
  assign pd_req       = expired;
  assign bal_override = expired;  // power-down outranks balancing
endmodule

// File: rtl/pdt_timer_chk.sv
module pdt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tick,
  input logic       pd_req,
  input logic       bal_override
);
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & 8'hF8));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2:0] == 3'b000);

  assert_expiry_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_req) |-> ($past(tick) && !$past(wr_en)));

  assert_zero_code_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req && rd_data[7:3] == 5'd0) |=> !pd_req);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !wr_en) |=> pd_req);

  assert_override_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bal_override == pd_req);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !pd_req);
endmodule

bind pdt_timer pdt_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .tick         (tick),
  .pd_req       (pd_req),
  .bal_override (bal_override)
);

// File: tb/pdt_timer_bench.sv
`timescale 1ns/1ps
module pdt_timer_bench;
  localparam int STEP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick = 1'b0;
  logic [7:0] rd_data;
  logic       pd_req;
  logic       bal_override;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdt_timer #(.STEP_TICKS(STEP)) u_pdt_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .tick         (tick),
    .pd_req       (pd_req),
    .bal_override (bal_override)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pd(input string req, input logic exp);
    check(req, {7'd0, pd_req}, {7'd0, exp});
    check({req, "/R6"}, {7'd0, bal_override}, {7'd0, exp});
  endtask

  task automatic do_write(input logic [7:0] d, input logic with_tick);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 8'h00);
    check_pd("R1 pd", 1'b0);
  endtask

  task automatic t_readback;
    do_write(8'hFF, 1'b0);
    check("R2 ff", rd_data, 8'hF8);
    do_write(8'h57, 1'b0);
    check("R2 57", rd_data, 8'h50);
  endtask

  task automatic t_expiry;
    do_write(8'h10, 1'b0);            // code 2
    ticks(2 * STEP - 1);
    check_pd("R3 before", 1'b0);
    ticks(1);
    check_pd("R3 at", 1'b1);
  endtask

  task automatic t_hold;
    ticks(10);
    repeat (5) @(negedge clk);
    check_pd("R5 hold", 1'b1);
  endtask

  task automatic t_zero;
    do_write(8'h07, 1'b0);            // code 0, reserved bits set
    check_pd("R7 clear", 1'b0);
    check("R2 zero", rd_data, 8'h00);
    ticks(40);
    check_pd("R4 disabled", 1'b0);
  endtask

  task automatic t_restart;
    do_write(8'h08, 1'b0);            // code 1
    ticks(STEP - 1);
    do_write(8'h08, 1'b0);
    ticks(STEP - 1);
    check_pd("R7 partial dropped", 1'b0);
    ticks(1);
    check_pd("R7 restart expiry", 1'b1);
  endtask

  task automatic t_same_cycle;
    do_write(8'h0F, 1'b1);            // code 1, reserved bits ignored, tick with write
    check_pd("R7 clear2", 1'b0);
    ticks(STEP - 1);
    check_pd("R8 before", 1'b0);
    ticks(1);
    check_pd("R8 at", 1'b1);
  endtask

  task automatic t_max;
    do_write(8'hF8, 1'b0);
    ticks(31 * STEP - 1);
    check_pd("R9 before", 1'b0);
    ticks(1);
    check_pd("R9 at", 1'b1);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_pd("R1 in reset", 1'b0);
    check("R1 rd in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    ticks(5);
    check_pd("R1 after reset", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_expiry();
    t_hold();
    t_zero();
    t_restart();
    t_same_cycle();
    t_max();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule